// File: doc/BRIEF.md
# Programmable Run-Length Input Glitch Filter

This block cleans up one asynchronous two-wire bus input, such as the data or the clock line of a serial bus. The raw pin is first brought into the reference clock domain by a two-flop synchroniser. The filtered output moves to a new level only after the synchronised samples have shown that level for a programmable number of consecutive cycles. Any sample that goes back to the current output level cancels the run in progress, so that short spikes never reach the output.

The run length comes from a 4-bit setting through a non-linear map. Settings 0 to 7 ask for that many samples. Settings 8 to 15 go up in steps of two, from 9 to 23 samples. A setting of 0 bypasses the filter, and the synchronised input goes straight to the output. A one-cycle strobe marks each falling and each rising edge of the filtered output. A design with a data line and a clock line places two copies, each with its own setting. The suggested power-up setting is 2, which is exported from the package as `GF_RESET_CODE`.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `filt_out` is 1 and both strobes are 0.
- R2: The raw input passes through two synchronising flops. With setting 0, a level driven on `raw_in` before clock edge k shows on `filt_out` right after edge k+1.
- R3: For settings 0 to 7 the required run N equals the setting. A new input level held long enough shows on `filt_out` right after edge k+1+N.
- R4: Settings 8 to 15 require N = 2*setting-7 samples (9, 11, ..., 23). The latency rule of R3 still applies.
- R5: An input run shorter than N samples leaves `filt_out` unchanged, and no strobe is produced.
- R6: A sample equal to the present output level restarts the run count from zero. The next run then needs N fresh samples.
- R7: `rise_stb` is high for exactly one cycle, in the cycle in which `filt_out` goes from 0 to 1.
- R8: `fall_stb` is high for exactly one cycle, in the cycle in which `filt_out` goes from 1 to 0. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | 1 | Asynchronous raw bus input |
| run_code | input | 4 | Run-length setting (0 = bypass) |
| filt_out | output | 1 | Filtered level, idle 1 |
| rise_stb | output | 1 | One-cycle strobe on a filtered rising edge |
| fall_stb | output | 1 | One-cycle strobe on a filtered falling edge |

## Verification
The edge strobe of one transition and the restart of the run count for the opposite level can fall in the same cycle. The filtered output flips at the same edge that the next opposite-level sample arrives. The bench provokes this with setting 2 and back-to-back two-cycle pulses. It judges the result by the exact negedge on which each of the two falls and the two rises shows, and by the number of strobes of each kind. A restart that was lost or taken twice would shift the second fall.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
    localparam int GF_CODE_W     = 4;
    localparam int GF_MAX_RUN    = 23;
    localparam int GF_CNT_W      = $clog2(GF_MAX_RUN + 1);
    localparam int GF_RESET_CODE = 2;
    localparam int GF_LINEAR_TOP = 7;
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2,
    parameter bit IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{IDLE}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gf_run_decode.sv
module gf_run_decode
    import glitch_filter_pkg::*;
#(
    parameter int CODE_W    = GF_CODE_W,
    parameter int CNT_W     = GF_CNT_W,
    parameter int LINEAR_TOP = GF_LINEAR_TOP
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  need_o,
    output logic              bypass_o
);
    localparam int WIDE = CNT_W + 2;
    logic [WIDE-1:0] code_w;

    always_comb begin
        code_w = WIDE'(code_i);
        if (code_w <= WIDE'(LINEAR_TOP)) need_o = CNT_W'(code_w);
        else                             need_o = CNT_W'((code_w << 1) - WIDE'(LINEAR_TOP));
        bypass_o = (code_i == '0);
    end
endmodule

// File: rtl/gf_run_core.sv
module gf_run_core
    import glitch_filter_pkg::*;
#(
    parameter int CNT_W = GF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_i,
    input  logic [CNT_W-1:0] need_i,
    input  logic             bypass_i,
    output logic             filt_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] run;
        logic             prev;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CNT_W:0] run_inc;
    logic           filt_c;

    always_comb begin
        st_d    = st_q;
        run_inc = {1'b0, st_q.run} + 1'b1;
        if (bypass_i) begin
            st_d.level = sample_i;
            st_d.run   = '0;
        end else if (sample_i == st_q.level) begin
            st_d.run = '0;
        end else if (run_inc >= {1'b0, need_i}) begin
            st_d.level = sample_i;
            st_d.run   = '0;
        end else begin
            st_d.run = run_inc[CNT_W-1:0];
        end
        filt_c    = bypass_i ? sample_i : st_q.level;
        st_d.prev = filt_c;
        filt_o    = filt_c;
        rise_o    = filt_c & ~st_q.prev;
        fall_o    = ~filt_c & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= 1'b1;
            st_q.run   <= '0;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the held level only moves towards a sample that differed from it
    a_r5_move_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bypass_i) && st_q.level != $past(st_q.level))
            |-> $past(sample_i) != $past(st_q.level));

    // R6: a sample equal to the output clears the run count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && sample_i == st_q.level) |=> st_q.run == '0);

    // R8: strobes never coincide
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import glitch_filter_pkg::*;
#(
    parameter int CODE_W      = GF_CODE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_in,
    input  logic [CODE_W-1:0] run_code,
    output logic              filt_out,
    output logic              rise_stb,
    output logic              fall_stb
);
    localparam int CNT_W = GF_CNT_W;

    logic             sample;
    logic [CNT_W-1:0] need;
    logic             bypass;

    gf_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sample)
    );

    gf_run_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
        .code_i(run_code), .need_o(need), .bypass_o(bypass)
    );

    gf_run_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .need_i(need),
        .bypass_i(bypass), .filt_o(filt_out), .rise_o(rise_stb), .fall_o(fall_stb)
    );

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2: in bypass the output is the raw input two edges late
    a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && run_code == '0) |-> filt_out == $past(raw_in, 2));

    // R7: a rising strobe comes only with a 0-to-1 output change
    a_r7_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && rise_stb) |-> (filt_out && !$past(filt_out)));
endmodule

// File: tb/glitch_filter_test.sv
module glitch_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b1;
    logic [3:0] run_code = 4'd2;
    logic       filt_out, rise_stb, fall_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glitch_filter uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .run_code(run_code),
        .filt_out(filt_out), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    // {code, low width, expect pass}
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd0,  8'd1,  4'd1}, {4'd1,  8'd1,  4'd1}, {4'd2,  8'd1,  4'd0},
        {4'd2,  8'd2,  4'd1}, {4'd5,  8'd4,  4'd0}, {4'd5,  8'd5,  4'd1},
        {4'd7,  8'd7,  4'd1}, {4'd8,  8'd8,  4'd0}, {4'd8,  8'd9,  4'd1},
        {4'd11, 8'd14, 4'd0}, {4'd13, 8'd19, 4'd1}, {4'd15, 8'd22, 4'd0},
        {4'd15, 8'd23, 4'd1}
    };

    function automatic int need_of(input int c);
        return (c <= 7) ? c : 2 * c - 7;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives raw low on negedge i when lowmask[i]; samples before driving
    task automatic run_pattern(input logic [3:0] c, input logic [31:0] lowmask, input int len,
                               output int t_low, output int t_high, output int t_low2,
                               output int nf, output int nr);
        run_code = c;
        t_low = -1; t_high = -1; t_low2 = -1; nf = 0; nr = 0;
        @(negedge clk);
        raw_in = ~lowmask[0];
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (!filt_out && t_low < 0) t_low = i;
            else if (filt_out && t_low >= 0 && t_high < 0) t_high = i;
            else if (!filt_out && t_high >= 0 && t_low2 < 0) t_low2 = i;
            if (fall_stb) nf++;
            if (rise_stb) nr++;
            raw_in = (i < 32) ? ~lowmask[i] : 1'b1;
        end
        raw_in = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int tl, th, tl2, nf, nr, n, w, len;
        logic [31:0] mask;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 filt_out in reset", int'(filt_out), 1);
        check("R1 strobes in reset", int'(rise_stb) + int'(fall_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 filt_out after reset", int'(filt_out), 1);
        check("R1 strobes after reset", int'(rise_stb) + int'(fall_stb), 0);
        repeat (4) @(negedge clk);

        // table walk: R2 R3 R4 R5 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            n = need_of(int'(VEC[v][15:12]));
            w = int'(VEC[v][11:4]);
            mask = (32'd1 << w) - 32'd1;
            len = w + n + 6;
            run_pattern(VEC[v][15:12], mask, len, tl, th, tl2, nf, nr);
            if (VEC[v][0]) begin
                check($sformatf("R3/R4/R2 fall time code %0d", VEC[v][15:12]), tl, 2 + n);
                check($sformatf("R3/R4 rise time code %0d", VEC[v][15:12]), th, w + 2 + n);
                check("R8 one fall strobe", nf, 1);
                check("R7 one rise strobe", nr, 1);
            end else begin
                check($sformatf("R5 short run ignored code %0d", VEC[v][15:12]), tl, -1);
                check("R5 no strobes", nf + nr, 0);
            end
        end

        // R6: code 4, low 3, high 1, low 4 -> fall seen at 4+2+4
        run_pattern(4'd4, 32'b1111_0111, 20, tl, th, tl2, nf, nr);
        check("R6 restarted run fall time", tl, 10);
        check("R6 single fall strobe", nf, 1);

        // R6 with R7/R8 in the same cycle: code 2, pulses low 2, high 2, low 2
        run_pattern(4'd2, 32'b11_00_11, 16, tl, th, tl2, nf, nr);
        check("R8 first fall", tl, 4);
        check("R7 rise meets restart", th, 6);
        check("R6 second fall", tl2, 8);
        check("R8 two fall strobes", nf, 2);
        check("R7 two rise strobes", nr, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule